// File: doc/BRIEF.md
# Clock-Source Control Register with Write Protection

This block is the main clock-control register of a small reset and clock controller. It holds the enable and ready bits for four clock sources: a multi-speed internal oscillator, a 16 MHz internal oscillator, an external oscillator and a main PLL. It also holds the multi-speed oscillator range selection. Software writes it through a one-cycle write port. Every control write is checked against two inputs: the system-clock switch status and the PLL input source. A write that would stop the clock currently feeding the system, directly or through the PLL, is refused or overridden.

After each accepted control write the block recomputes the ready bits and raises ready flags. It also drives the frequency of the multi-speed oscillator, taken from a fixed 12-entry table. An out-of-range selection is rejected by putting back the range field's earlier value. The ready flags are cleared by writing ones to a clear port. The interrupt output combines the flags with a per-flag enable register.

Top module: `clk_src_ctl`

## Requirements
- R1: After reset the control word reads 0x00000067 (multi-speed enable bit 0 = 1, ready bit 1 = 1, range-select bit 2 = 1, range field [7:4] = 6). The multi-speed frequency reads 4000000. The flags, flag enables and irq read 0, and the standby range reads 6.
- R2: `wr_sel` picks the target of a write: 0 = control word, 1 = flag enables (data [3:0]), 2 = flag clear, 3 = standby range (data [3:0]).
  - In a control write, bits 0, 2, [7:4], 8, 16 and 24 take the written value, subject to R4 to R8.
  - The ready bits 1, 10, 17 and 25 ignore the written data.
  - All other bits read 0.
- R3: The multi-speed frequency comes from a table indexed 0 to 11: 100k, 200k, 400k, 800k, 1M, 2M, 4M, 8M, 16M, 24M, 32M, 48M Hz.
  - The index is control bits [7:4] when range-select bit 2 of the written word is 1.
  - Otherwise the index is the standby range.
  - The frequency is recomputed only on control writes, and only while the multi-speed oscillator runs after the write.
- R4: If the index is 12 or more while the oscillator runs, the frequency keeps its old value and control bits [7:4] return to their value before the write.
- R5: While `sws` = 2'b11 (PLL drives the system), a control write leaves PLL enable bit 24 at 1. PLL ready bit 25 and PLL flag 3 are left unchanged.
- R6: While `sws` = 2'b10 or `pll_src` = 3 (external oscillator), a control write forces external enable bit 16 to 1. Ready bit 17 and flag 2 are left unchanged.
- R7: While `sws` = 2'b01 or `pll_src` = 2 (16 MHz oscillator), a control write forces bits 8 and 10 to 1 and counts as the 16 MHz source being ready.
- R8: While `sws` = 2'b00 or `pll_src` = 1 (multi-speed oscillator), a control write forces bits 0 and 1 to 1. Flag 0 may be raised only if bit 0 was 0 before the write.
- R9: For a source with no protection, its ready bit equals its written enable bit after a control write. A disabled multi-speed oscillator reports frequency 0.
- R10: A control write that leaves a source ready sets that source's flag if its enable bit is 1; the flags are ms = 0, 16 MHz = 1, external = 2, PLL = 3 (R8 limits flag 0 in the forced case). A clear write drops every flag whose data bit is 1.
- R11: `irq` is 1 exactly when some flag and its matching enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 32 | Write data |
| sws | input | 2 | System-clock switch status |
| pll_src | input | 2 | PLL input source (0 none, 1 ms, 2 16 MHz, 3 external) |
| ctrl_q | output | 32 | Control word |
| stby_q | output | 4 | Standby range index |
| ie_q | output | 4 | Flag enables |
| flags_q | output | 4 | Ready flags |
| irq | output | 1 | Interrupt request |
| ms_freq_hz | output | 32 | Multi-speed oscillator frequency in Hz |

## Verification
The assertions assume that `sws` and `pll_src` are synchronous to `clk` and stable at the rising edge that takes a write. The protection properties compare the state after an edge with the input values sampled at that edge. The stimulus changes every input only on the falling edge, so each write sees one consistent switch status and PLL source. The random phase hits every protection combination, invalid range indices from both the control field and the standby register, and clear writes mixed in with flag-raising writes.

// File: rtl/clk_src_ctl.sv
module clk_src_ctl #(
  parameter int unsigned DW        = 32,
  parameter int unsigned FW        = 32,
  parameter logic [3:0]  RST_RANGE = 4'd6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    sws,
  input  logic [1:0]    pll_src,
  output logic [DW-1:0] ctrl_q,
  output logic [3:0]    stby_q,
  output logic [3:0]    ie_q,
  output logic [3:0]    flags_q,
  output logic          irq,
  output logic [FW-1:0] ms_freq_hz
);
  localparam int MS_EN = 0, MS_RDY = 1, RSEL = 2, RNG_LO = 4;
  localparam int HI_EN = 8, HI_RDY = 10, EXT_EN = 16, EXT_RDY = 17;
  localparam int PLL_EN = 24, PLL_RDY = 25;
  localparam logic [DW-1:0] RO_MASK = (DW'(1) << MS_RDY) | (DW'(1) << HI_RDY) |
                                      (DW'(1) << EXT_RDY) | (DW'(1) << PLL_RDY);
  localparam logic [DW-1:0] WR_MASK = (DW'(1) << MS_EN) | (DW'(1) << RSEL) |
                                      (DW'(15) << RNG_LO) | (DW'(1) << HI_EN) |
                                      (DW'(1) << EXT_EN) | (DW'(1) << PLL_EN);
  localparam int unsigned NRANGE = 12;
  localparam logic [DW-1:0] RST_CTRL = (DW'(1) << MS_EN) | (DW'(1) << MS_RDY) |
                                       (DW'(1) << RSEL) | (DW'(RST_RANGE) << RNG_LO);

  function automatic logic [FW-1:0] range_hz(input logic [3:0] idx);
    case (idx)
      4'd0:  range_hz = FW'(100_000);
      4'd1:  range_hz = FW'(200_000);
      4'd2:  range_hz = FW'(400_000);
      4'd3:  range_hz = FW'(800_000);
      4'd4:  range_hz = FW'(1_000_000);
      4'd5:  range_hz = FW'(2_000_000);
      4'd6:  range_hz = FW'(4_000_000);
      4'd7:  range_hz = FW'(8_000_000);
      4'd8:  range_hz = FW'(16_000_000);
      4'd9:  range_hz = FW'(24_000_000);
      4'd10: range_hz = FW'(32_000_000);
      default: range_hz = FW'(48_000_000);
    endcase
  endfunction

  wire ctl_wr = wr_en && (wr_sel == 2'd0);
  wire pll_busy = (sws == 2'b11);
  wire ext_busy = (sws == 2'b10) || (pll_src == 2'd3);
  wire hi_busy  = (sws == 2'b01) || (pll_src == 2'd2);
  wire ms_busy  = (sws == 2'b00) || (pll_src == 2'd1);

  logic [DW-1:0] cand, ctrl_n;
  logic [3:0]    rdy_ev, idx;
  logic [FW-1:0] freq_n;
  logic          ms_run;

  assign cand = (ctrl_q & RO_MASK) | (wr_data & WR_MASK);
  assign idx  = cand[RSEL] ? cand[RNG_LO +: 4] : stby_q;

  always_comb begin
    ctrl_n = cand;
    rdy_ev = '0;
    freq_n = ms_freq_hz;
    if (pll_busy) ctrl_n[PLL_EN] = 1'b1;
    else begin
      ctrl_n[PLL_RDY] = cand[PLL_EN];
      rdy_ev[3] = cand[PLL_EN];
    end
    if (ext_busy) ctrl_n[EXT_EN] = 1'b1;
    else begin
      ctrl_n[EXT_RDY] = cand[EXT_EN];
      rdy_ev[2] = cand[EXT_EN];
    end
    if (hi_busy) begin
      ctrl_n[HI_EN]  = 1'b1;
      ctrl_n[HI_RDY] = 1'b1;
      rdy_ev[1] = 1'b1;
    end else begin
      ctrl_n[HI_RDY] = cand[HI_EN];
      rdy_ev[1] = cand[HI_EN];
    end
    if (ms_busy) begin
      ctrl_n[MS_EN]  = 1'b1;
      ctrl_n[MS_RDY] = 1'b1;
      rdy_ev[0] = !ctrl_q[MS_EN];
      ms_run = 1'b1;
    end else begin
      ctrl_n[MS_RDY] = cand[MS_EN];
      rdy_ev[0] = cand[MS_EN];
      ms_run = cand[MS_EN];
    end
    if (!ms_run) freq_n = '0;
    else if (idx < 4'(NRANGE)) freq_n = range_hz(idx);
    else ctrl_n[RNG_LO +: 4] = ctrl_q[RNG_LO +: 4];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= RST_CTRL;
      stby_q     <= RST_RANGE;
      ie_q       <= '0;
      flags_q    <= '0;
      ms_freq_hz <= range_hz(RST_RANGE);
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: begin
          ctrl_q     <= ctrl_n;
          ms_freq_hz <= freq_n;
          flags_q    <= flags_q | (rdy_ev & ie_q);
        end
        2'd1: ie_q    <= wr_data[3:0];
        2'd2: flags_q <= flags_q & ~wr_data[3:0];
        default: stby_q <= wr_data[3:0];
      endcase
    end
  end

  assign irq = |(flags_q & ie_q);

  // R5
  pll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && pll_busy) |=> ctrl_q[PLL_EN]);
  // R6
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ext_busy) |=> ctrl_q[EXT_EN]);
  // R7
  hi_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && hi_busy) |=> (ctrl_q[HI_EN] && ctrl_q[HI_RDY]));
  // R9
  ms_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[MS_RDY] == ctrl_q[MS_EN]);
  // R9
  ms_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[MS_EN] |-> (ms_freq_hz == '0));
  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && wr_data[0]) |=> !flags_q[0]);
endmodule

// File: tb/clk_src_ctl_test.sv
`timescale 1ns/1ps
module clk_src_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0, sws = '0, pll_src = 2'd1;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_q, ms_freq_hz;
  logic [3:0] stby_q, ie_q, flags_q;
  logic irq;

  always #2 clk = ~clk;

  clk_src_ctl uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sws(sws), .pll_src(pll_src), .ctrl_q(ctrl_q),
    .stby_q(stby_q), .ie_q(ie_q), .flags_q(flags_q), .irq(irq),
    .ms_freq_hz(ms_freq_hz));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int m_ms_en, m_ms_rdy, m_rsel, m_rng, m_hi_en, m_hi_rdy;
  int m_ext_en, m_ext_rdy, m_pll_en, m_pll_rdy, m_stby, m_ie, m_flags;
  longint m_freq;

  function automatic longint tab_hz(int i);
    longint t[12] = '{100000, 200000, 400000, 800000, 1000000, 2000000,
                      4000000, 8000000, 16000000, 24000000, 32000000, 48000000};
    return t[i];
  endfunction

  function automatic logic [31:0] exp_ctrl();
    logic [31:0] v = '0;
    v[0] = m_ms_en[0]; v[1] = m_ms_rdy[0]; v[2] = m_rsel[0]; v[7:4] = m_rng[3:0];
    v[8] = m_hi_en[0]; v[10] = m_hi_rdy[0]; v[16] = m_ext_en[0];
    v[17] = m_ext_rdy[0]; v[24] = m_pll_en[0]; v[25] = m_pll_rdy[0];
    return v;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ms_en = 1; m_ms_rdy = 1; m_rsel = 1; m_rng = 6; m_hi_en = 0; m_hi_rdy = 0;
    m_ext_en = 0; m_ext_rdy = 0; m_pll_en = 0; m_pll_rdy = 0; m_stby = 6;
    m_ie = 0; m_flags = 0; m_freq = 4000000;
  endtask

  task automatic compare_all();
    logic [31:0] e = exp_ctrl();
    chk("R2 ctrl word", ctrl_q, e);
    chk("R5 pll bits", {ctrl_q[25], ctrl_q[24]}, {e[25], e[24]});
    chk("R6 ext bits", {ctrl_q[17], ctrl_q[16]}, {e[17], e[16]});
    chk("R7 hi bits", {ctrl_q[10], ctrl_q[8]}, {e[10], e[8]});
    chk("R8 ms bits", ctrl_q[1:0], e[1:0]);
    chk("R9 ready bits", {ctrl_q[25], ctrl_q[17], ctrl_q[10], ctrl_q[1]},
        {e[25], e[17], e[10], e[1]});
    chk("R4 range field", ctrl_q[7:4], e[7:4]);
    chk("R3 ms freq", ms_freq_hz, m_freq);
    chk("R2 stby/ie", {stby_q, ie_q}, {m_stby[3:0], m_ie[3:0]});
    chk("R10 flags", flags_q, m_flags);
    chk("R11 irq", irq, (m_flags & m_ie) != 0);
  endtask

  task automatic model_write(logic [1:0] sel, logic [31:0] d, logic [1:0] s, logic [1:0] src);
    int old_rng = m_rng, old_ms = m_ms_en, run, idx, ev = 0;
    if (sel == 1) begin m_ie = d[3:0]; return; end
    if (sel == 2) begin m_flags = m_flags & ~int'(d[3:0]); return; end
    if (sel == 3) begin m_stby = d[3:0]; return; end
    m_ms_en = d[0]; m_rsel = d[2]; m_rng = d[7:4]; m_hi_en = d[8];
    m_ext_en = d[16]; m_pll_en = d[24];
    if (s == 3) m_pll_en = 1;
    else begin m_pll_rdy = m_pll_en; if (m_pll_rdy) ev |= 8; end
    if (s == 2 || src == 3) m_ext_en = 1;
    else begin m_ext_rdy = m_ext_en; if (m_ext_rdy) ev |= 4; end
    if (s == 1 || src == 2) begin m_hi_en = 1; m_hi_rdy = 1; ev |= 2; end
    else begin m_hi_rdy = m_hi_en; if (m_hi_rdy) ev |= 2; end
    if (s == 0 || src == 1) begin
      m_ms_en = 1; m_ms_rdy = 1; run = 1; if (old_ms == 0) ev |= 1;
    end else begin
      m_ms_rdy = m_ms_en; run = m_ms_en; if (m_ms_en) ev |= 1;
    end
    idx = m_rsel ? m_rng : m_stby;
    if (!run) m_freq = 0;
    else if (idx < 12) m_freq = tab_hz(idx);
    else m_rng = old_rng;
    m_flags |= (ev & m_ie);
  endtask

  task automatic step(bit we, logic [1:0] sel, logic [31:0] d, logic [1:0] s, logic [1:0] src);
    @(negedge clk);
    compare_all();
    wr_en = we; wr_sel = sel; wr_data = d; sws = s; pll_src = src;
    if (we) model_write(sel, d, s, src);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values, stated constants
    chk("R1 ctrl reset", ctrl_q, 32'h67);
    chk("R1 freq reset", ms_freq_hz, 4000000);
    chk("R1 flags/ie/irq", {flags_q, ie_q, irq}, 9'd0);
    chk("R1 stby reset", stby_q, 6);
    step(1, 1, 32'hF, 2'b00, 2'd1);
    // R7 / R10 hi forced by pll source
    step(1, 0, 32'h0000_0085, 2'b00, 2'd2);
    step(0, 0, 0, 2'b00, 2'd2);
    chk("R7 hi forced ready", ctrl_q[10], 1'b1);
    // R4 invalid range via control field, freq kept
    step(1, 0, 32'h0000_00F5, 2'b00, 2'd1);
    step(0, 0, 0, 2'b00, 2'd1);
    chk("R4 range restored", ctrl_q[7:4], 4'd8);
    chk("R3 freq index 8", ms_freq_hz, 16000000);
    // R3 standby index path
    step(1, 3, 32'd11, 2'b00, 2'd1);
    step(1, 0, 32'h0000_0001, 2'b00, 2'd1);
    step(0, 0, 0, 2'b00, 2'd1);
    chk("R3 standby 11", ms_freq_hz, 48000000);
    // R5 pll held while in use
    step(1, 0, 32'h0100_0001, 2'b00, 2'd0);
    step(1, 0, 32'h0000_0001, 2'b11, 2'd0);
    step(0, 0, 0, 2'b11, 2'd0);
    chk("R5 pll kept on", ctrl_q[25:24], 2'b11);
    // R9 ms off gives zero frequency
    step(1, 0, 32'h0000_0000, 2'b10, 2'd0);
    step(0, 0, 0, 2'b10, 2'd0);
    chk("R9 ms off freq 0", ms_freq_hz, 0);
    chk("R6 ext forced", ctrl_q[16], 1'b1);
    // R8 forced ms raises flag 0 once
    step(1, 2, 32'hF, 2'b10, 2'd0);
    step(1, 0, 32'h0000_0000, 2'b00, 2'd0);
    step(0, 0, 0, 2'b00, 2'd0);
    chk("R8 flag on first force", flags_q[0], 1'b1);
    step(1, 2, 32'h1, 2'b00, 2'd0);
    step(1, 0, 32'h0000_0000, 2'b00, 2'd0);
    step(0, 0, 0, 2'b00, 2'd0);
    chk("R8 no flag when already on", flags_q[0], 1'b0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d = $urandom;
      logic [1:0] sel = (($urandom % 4) == 0) ? 2'($urandom) : 2'd0;
      step($urandom % 4 != 0, sel, d, 2'($urandom), 2'($urandom));
    end
    step(0, 0, 0, 2'b00, 2'd1);
    step(0, 0, 0, 2'b00, 2'd1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule